// File: doc/BRIEF.md
# PRBS Receive Pattern Synchronizer

This block aligns a local pseudo-random sequence generator with a serial test stream that carries a PRBS or QRSS pattern, and then keeps watching whether that alignment holds. Each bit arrives with a valid strobe. The block has three states:

- **Seeding:** received bits are copied straight into the generator.
- **Checking:** the generator runs freely and its output is compared with the stream. One wrong bit restarts the seeding.
- **Locked:** every mismatch is reported as an error pulse, and a sliding window of recent bits decides whether the lock has been lost.

A polynomial select picks the sequence. An invert control lets the block accept a complemented stream. An auto-resync disable keeps the block locked however many errors it sees. A rising edge on the manual resync input forces a fresh search at any time. A one-cycle resync pulse marks each restart of the search, so a bit-error counter outside the block can use it to drop its counts.

Top module: `prbs_rx_lock`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the block is seeding, with `locked`, `bit_err` and `resync_pulse` all 0.
- R2: While seeding, each bit presented with `bit_vld`=1 is shifted into the generator as seed. After 32 such bits the block starts checking. Cycles with `bit_vld`=0 are ignored in every state.
- R3: While checking, each of the next 32 valid bits is compared with the generator output. If all 32 match, `locked` goes to 1 in the cycle after the last of them, so a clean stream is locked after exactly 64 valid bits.
- R4: A single mismatch while checking returns the block to seeding. `resync_pulse` is 1 for one cycle on every return to seeding, and `bit_err` stays 0.
- R5: While locked, a valid bit that differs from the generator output makes `bit_err` 1 for exactly the following cycle. `bit_err` is never 1 for a bit that arrives outside the locked state.
- R6: While locked, once 6 of the last 64 valid bits are errors, `locked` drops and `resync_pulse` fires on the bit that makes the sixth. Errors more than 64 valid bits old no longer count, so 5 errors, then 70 clean bits, then 5 more errors keep the lock.
- R7: With `auto_resync_dis`=1 the error count never ends the lock, however many errors arrive.
- R8: A 0-to-1 change on `manual_resync` returns the block to seeding one clock later, whatever the state and whatever the value of `auto_resync_dis`. Holding `manual_resync` high has no further effect.
- R9: With `invert_en`=1 each received bit is complemented before it is used. A complemented stream then locks after 64 valid bits, and it never locks while `invert_en`=0.
- R10: `poly_sel` picks the recurrence x[n]=x[n-a] xor x[n-b], where 0 gives (a,b)=(15,14), 1 gives (23,18), 2 gives QRSS with (20,17), and 3 gives (9,5).
- R11: In QRSS mode an expected output bit is forced to 1 whenever the previous 14 output bits were all 0. The generator's shift state still takes the unforced recurrence bit, so a stream with such forced ones stays locked with no errors.
- R12: The error window is emptied on every return to seeding, so errors seen before a manual resync do not count toward 6 after the block locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Received serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| poly_sel | input | 2 | Pattern select (see R10) |
| invert_en | input | 1 | Complements received bits before use |
| auto_resync_dis | input | 1 | 1 stops the error window from ending a lock |
| manual_resync | input | 1 | A rising edge forces a new search |
| locked | output | 1 | 1 while in the locked state |
| bit_err | output | 1 | One-cycle pulse for each mismatched bit while locked |
| resync_pulse | output | 1 | One-cycle pulse on each return to seeding |

## Verification
Every output comes from a register that updates on the clock edge that takes in the valid bit or the manual edge. Each result is therefore due exactly one edge after the stimulus that causes it. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so it checks that first edge and not a later one. Lock timing is checked on both sides of the boundary: `locked` must still be 0 after 63 valid bits and must be 1 after the 64th, with idle cycles mixed in that must not count.

// File: rtl/prbs_lock_pkg.sv
// Shared types and pattern definitions for the PRBS receive synchronizer.
// Assumes the generator shift register keeps its newest bit in position 0.
// The tap functions return zero-based indices into that register.
package prbs_lock_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_SYNC   = 2'd2
    } lock_st_t;

    localparam logic [1:0] PSEL_P15  = 2'd0;
    localparam logic [1:0] PSEL_P23  = 2'd1;
    localparam logic [1:0] PSEL_QRSS = 2'd2;
    localparam logic [1:0] PSEL_P9   = 2'd3;

    // Zero-run length after which QRSS forces a one
    localparam int QRSS_ZMAX = 14;

    // Index of the longer tap, x[n-a], for each pattern
    function automatic logic [4:0] tap_far(input logic [1:0] sel);
        case (sel)
            PSEL_P15:  tap_far = 5'd14;
            PSEL_P23:  tap_far = 5'd22;
            PSEL_QRSS: tap_far = 5'd19;
            default:   tap_far = 5'd8;
        endcase
    endfunction

    // Index of the shorter tap, x[n-b], for each pattern
    function automatic logic [4:0] tap_near(input logic [1:0] sel);
        case (sel)
            PSEL_P15:  tap_near = 5'd13;
            PSEL_P23:  tap_near = 5'd17;
            PSEL_QRSS: tap_near = 5'd16;
            default:   tap_near = 5'd4;
        endcase
    endfunction

endpackage

// File: rtl/prbs_rx_gen.sv
// Receive pattern generator: a Fibonacci shift register with selectable taps.
// In seed mode it shifts in the received bit. Otherwise it shifts in its own
// recurrence bit and offers that bit as the expected value.
// QRSS zero suppression changes only the expected output, never the shift state.
// Assumes GEN_W is at least the longest tap (23).
module prbs_rx_gen
    import prbs_lock_pkg::*;
#(
    parameter int GEN_W   = 23,
    parameter bit QRSS_EN = 1'b1,
    parameter int ZMAX    = QRSS_ZMAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       seed_mode,
    input  logic       rx_bit,
    input  logic [1:0] poly_sel,
    output logic       exp_bit
);
    localparam int ZW = $clog2(ZMAX + 1);

    logic [GEN_W-1:0] lfsr_q;
    logic             raw_bit;

    // Recurrence bit from the two selected taps
    assign raw_bit = lfsr_q[tap_far(poly_sel)] ^ lfsr_q[tap_near(poly_sel)];

    // Shift register: takes the seed or its own recurrence bit on each valid bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= '0;
        end else if (adv) begin
            lfsr_q <= {lfsr_q[GEN_W-2:0], seed_mode ? rx_bit : raw_bit};
        end
    end

    generate
        if (QRSS_EN) begin : g_zsup
            logic [ZW-1:0] zrun_q;
            logic          force_one;
            logic          out_bit;

            assign force_one = (poly_sel == PSEL_QRSS) && (zrun_q == ZW'(ZMAX));
            assign exp_bit   = raw_bit | force_one;
            assign out_bit   = seed_mode ? rx_bit : exp_bit;

            // Counts consecutive zero output bits, saturating at ZMAX
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    zrun_q <= '0;
                end else if (adv) begin
                    if (out_bit) begin
                        zrun_q <= '0;
                    end else if (zrun_q != ZW'(ZMAX)) begin
                        zrun_q <= zrun_q + 1'b1;
                    end
                end
            end

            // R11: a forced one must clear the zero run
            p_zrun_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (adv && !seed_mode && force_one) |=> (zrun_q == '0));
        end else begin : g_plain
            assign exp_bit = raw_bit;
        end
    endgenerate

endmodule

// File: rtl/prbs_err_window.sv
// Sliding error window: remembers the error flags of the last WIN_LEN valid
// locked bits and keeps a running count of them.
// cnt_next is the count that holds after the bit being offered this cycle.
// Assumes clr and shift may be high together; clr wins.
module prbs_err_window #(
    parameter int WIN_LEN = 64,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             err_in,
    output logic [CNT_W-1:0] cnt_next
);
    logic [WIN_LEN-1:0] hist_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               oldest;

    assign oldest   = hist_q[WIN_LEN-1];
    assign cnt_next = shift ? (cnt_q + CNT_W'(err_in) - CNT_W'(oldest)) : cnt_q;

    // Error history and running count, emptied on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (shift) begin
            hist_q <= {hist_q[WIN_LEN-2:0], err_in};
            cnt_q  <= cnt_next;
        end
    end

    // R12: a clear leaves an empty window
    p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R6: the count never exceeds the window length
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (cnt_q <= CNT_W'(WIN_LEN)));

endmodule

// File: rtl/prbs_lock_fsm.sv
// Lock controller: seeds for SEED_LEN valid bits, checks for VERIFY_LEN bits,
// then holds lock until the error window reaches ERR_LIMIT or a manual edge arrives.
// It produces the registered lock state, the error pulse and the resync pulse.
// Assumes man_rise is already a single-cycle edge.
module prbs_lock_fsm
    import prbs_lock_pkg::*;
#(
    parameter int SEED_LEN   = 32,
    parameter int VERIFY_LEN = 32,
    parameter int ERR_LIMIT  = 6,
    parameter int CNT_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             mismatch,
    input  logic [CNT_W-1:0] win_cnt_next,
    input  logic             auto_dis,
    input  logic             man_rise,
    output lock_st_t         st_q,
    output logic             bit_err_q,
    output logic             resync_q,
    output logic             win_clr,
    output logic             win_shift
);
    localparam int PH_MAX = (SEED_LEN > VERIFY_LEN) ? SEED_LEN : VERIFY_LEN;
    localparam int PH_W   = $clog2(PH_MAX);

    lock_st_t        st_d;
    logic [PH_W-1:0] ph_q, ph_d;
    logic            to_load;
    logic            err_d;

    // Next-state selection; a manual edge overrides everything
    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        to_load = 1'b0;
        if (man_rise) begin
            to_load = 1'b1;
        end else if (bit_vld) begin
            case (st_q)
                ST_LOAD: begin
                    if (ph_q == PH_W'(SEED_LEN - 1)) begin
                        st_d = ST_VERIFY;
                        ph_d = '0;
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (mismatch) begin
                        to_load = 1'b1;
                    end else if (ph_q == PH_W'(VERIFY_LEN - 1)) begin
                        st_d = ST_SYNC;
                        ph_d = '0;
                    end else begin
                        ph_d = ph_q + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (!auto_dis && (win_cnt_next >= CNT_W'(ERR_LIMIT))) begin
                        to_load = 1'b1;
                    end
                end
                default: to_load = 1'b1;
            endcase
        end
        if (to_load) begin
            st_d = ST_LOAD;
            ph_d = '0;
        end
    end

    assign err_d     = bit_vld && (st_q == ST_SYNC) && mismatch;
    assign win_clr   = to_load;
    assign win_shift = bit_vld && (st_q == ST_SYNC);

    // State, phase counter and output pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_LOAD;
            ph_q      <= '0;
            bit_err_q <= 1'b0;
            resync_q  <= 1'b0;
        end else begin
            st_q      <= st_d;
            ph_q      <= ph_d;
            bit_err_q <= err_d;
            resync_q  <= to_load;
        end
    end

    // R5: an error pulse follows only a bit seen while locked
    p_err_only_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err_q |-> ($past(st_q) == ST_SYNC));

    // R4: a resync pulse always coincides with the seeding state
    p_resync_in_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resync_q |-> (st_q == ST_LOAD));

    // R3: lock is entered only from the checking state
    p_lock_from_verify_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SYNC) && ($past(st_q) != ST_SYNC)) |-> ($past(st_q) == ST_VERIFY));

    // R7: with auto resync disabled and no manual edge, lock holds
    p_auto_dis_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SYNC) && auto_dis && !man_rise) |=> (st_q == ST_SYNC));

    // R8: a manual edge always restarts the search
    p_manual_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        man_rise |=> ((st_q == ST_LOAD) && resync_q));

endmodule

// File: rtl/prbs_rx_lock.sv
// PRBS receive pattern synchronizer top level.
// It conditions the input bit (inversion), detects the manual resync edge, and
// ties together the generator, the error window and the lock controller.
// Assumes bit_in and the controls are synchronous to clk.
module prbs_rx_lock
    import prbs_lock_pkg::*;
#(
    parameter int SEED_LEN   = 32,
    parameter int VERIFY_LEN = 32,
    parameter int WIN_LEN    = 64,
    parameter int ERR_LIMIT  = 6,
    parameter int GEN_W      = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    input  logic       bit_vld,
    input  logic [1:0] poly_sel,
    input  logic       invert_en,
    input  logic       auto_resync_dis,
    input  logic       manual_resync,
    output logic       locked,
    output logic       bit_err,
    output logic       resync_pulse
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    lock_st_t         st_q;
    logic             rx_bit;
    logic             exp_bit;
    logic             mismatch;
    logic             man_q;
    logic             man_rise;
    logic             win_clr;
    logic             win_shift;
    logic [CNT_W-1:0] win_cnt_next;

    assign rx_bit   = bit_in ^ invert_en;
    assign mismatch = rx_bit ^ exp_bit;
    assign man_rise = manual_resync & ~man_q;

    // Previous level of the manual resync input, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            man_q <= 1'b0;
        end else begin
            man_q <= manual_resync;
        end
    end

    prbs_rx_gen #(
        .GEN_W   (GEN_W),
        .QRSS_EN (1'b1),
        .ZMAX    (QRSS_ZMAX)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (bit_vld),
        .seed_mode (st_q == ST_LOAD),
        .rx_bit    (rx_bit),
        .poly_sel  (poly_sel),
        .exp_bit   (exp_bit)
    );

    prbs_err_window #(
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .shift    (win_shift),
        .err_in   (mismatch),
        .cnt_next (win_cnt_next)
    );

    prbs_lock_fsm #(
        .SEED_LEN   (SEED_LEN),
        .VERIFY_LEN (VERIFY_LEN),
        .ERR_LIMIT  (ERR_LIMIT),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld      (bit_vld),
        .mismatch     (mismatch),
        .win_cnt_next (win_cnt_next),
        .auto_dis     (auto_resync_dis),
        .man_rise     (man_rise),
        .st_q         (st_q),
        .bit_err_q    (bit_err),
        .resync_q     (resync_pulse),
        .win_clr      (win_clr),
        .win_shift    (win_shift)
    );

    assign locked = (st_q == ST_SYNC);

    // R2: an idle cycle outside a manual edge leaves the state unchanged
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !man_rise) |=> $stable(locked));

    // R6: a drop of lock always comes with a resync pulse
    p_drop_pulses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> resync_pulse);

endmodule

// File: tb/sim_prbs_rx_lock.sv
// Directed bench for the PRBS receive pattern synchronizer.
// Inputs change on the falling edge, and outputs are read on the next falling edge.
module sim_prbs_rx_lock;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_in;
    logic       bit_vld;
    logic [1:0] poly_sel;
    logic       invert_en;
    logic       auto_resync_dis;
    logic       manual_resync;
    logic       locked;
    logic       bit_err;
    logic       resync_pulse;

    int n_chk = 0;
    int n_bad = 0;

    // Stream model state
    logic [31:0] tx_h;
    int          tx_a, tx_b;
    bit          tx_qrss;
    int          qi;
    logic        inv_stream;
    logic        raw_q [0:419];
    logic        qseq  [0:419];

    always #10 clk = ~clk;

    prbs_rx_lock u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .bit_in          (bit_in),
        .bit_vld         (bit_vld),
        .poly_sel        (poly_sel),
        .invert_en       (invert_en),
        .auto_resync_dis (auto_resync_dis),
        .manual_resync   (manual_resync),
        .locked          (locked),
        .bit_err         (bit_err),
        .resync_pulse    (resync_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Select the stream recurrence for a pattern code (R10)
    task automatic set_pattern(input logic [1:0] sel);
        poly_sel = sel;
        tx_qrss  = (sel == 2'd2);
        case (sel)
            2'd0: begin tx_a = 15; tx_b = 14; end
            2'd1: begin tx_a = 23; tx_b = 18; end
            2'd2: begin tx_a = 20; tx_b = 17; end
            default: begin tx_a = 9; tx_b = 5; end
        endcase
    endtask

    task automatic next_tx(output logic b);
        if (tx_qrss) begin
            b = qseq[qi];
            qi++;
        end else begin
            b = tx_h[tx_a-1] ^ tx_h[tx_b-1];
            tx_h = {tx_h[30:0], b};
        end
    endtask

    // Present one valid bit; returns at the falling edge after it is taken in
    task automatic push(input logic b);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_good(input int n);
        logic b;
        for (int i = 0; i < n; i++) begin
            next_tx(b);
            push(b ^ inv_stream);
        end
    endtask

    task automatic send_bad();
        logic b;
        next_tx(b);
        push(~b ^ inv_stream);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bit_in  = i[0];
            bit_vld = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n           = 1'b0;
        bit_in          = 1'b0;
        bit_vld         = 1'b0;
        invert_en       = 1'b0;
        auto_resync_dis = 1'b0;
        manual_resync   = 1'b0;
        inv_stream      = 1'b0;
        tx_h            = 32'hACE1_2345;
        qi              = 0;
        set_pattern(sel);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(2'd0);
        chk("R1 locked after reset", int'(locked), 0);
        chk("R1 bit_err after reset", int'(bit_err), 0);
        chk("R1 resync_pulse after reset", int'(resync_pulse), 0);
    endtask

    task automatic t_lock();
        do_reset(2'd0);
        send_good(20);
        idle(3);                       // R2: idle cycles must not count
        send_good(20);
        idle(2);
        send_good(23);
        chk("R3 not locked after 63 valid bits", int'(locked), 0);
        chk("R2 no error pulse while searching", int'(bit_err), 0);
        send_good(1);
        chk("R3 locked after 64 valid bits", int'(locked), 1);
        idle(4);
        chk("R2 lock held across idle cycles", int'(locked), 1);
    endtask

    task automatic t_verify_fail();
        do_reset(2'd0);
        send_good(32);
        send_bad();
        chk("R4 resync on checking mismatch", int'(resync_pulse), 1);
        chk("R4 no bit_err while checking", int'(bit_err), 0);
        chk("R4 not locked after mismatch", int'(locked), 0);
        idle(1);
        chk("R4 resync pulse lasts one cycle", int'(resync_pulse), 0);
        send_good(63);
        chk("R4 not locked 63 bits after restart", int'(locked), 0);
        send_good(1);
        chk("R4 locked 64 bits after restart", int'(locked), 1);
    endtask

    task automatic t_window();
        do_reset(2'd0);
        send_good(64);
        for (int i = 0; i < 5; i++) begin
            send_bad();
            chk("R5 bit_err after locked mismatch", int'(bit_err), 1);
            send_good(3);
            chk("R5 bit_err clear after clean bits", int'(bit_err), 0);
        end
        chk("R6 five errors keep lock", int'(locked), 1);
        send_good(70);
        for (int i = 0; i < 5; i++) begin
            send_bad();
            send_good(2);
        end
        chk("R6 old errors left the window", int'(locked), 1);
        send_bad();
        chk("R6 sixth error drops lock", int'(locked), 0);
        chk("R6 sixth error pulses resync", int'(resync_pulse), 1);
        chk("R5 sixth error still reported", int'(bit_err), 1);
    endtask

    task automatic t_auto_dis_manual();
        do_reset(2'd0);
        send_good(64);
        auto_resync_dis = 1'b1;
        for (int i = 0; i < 10; i++) begin
            send_bad();
        end
        chk("R7 lock kept with auto resync disabled", int'(locked), 1);
        chk("R7 errors still reported", int'(bit_err), 1);
        send_good(1);
        manual_resync = 1'b1;
        @(negedge clk);
        chk("R8 manual edge drops lock", int'(locked), 0);
        chk("R8 manual edge pulses resync", int'(resync_pulse), 1);
        idle(2);
        chk("R8 held level gives no second pulse", int'(resync_pulse), 0);
        manual_resync = 1'b0;
        send_good(64);
        chk("R8 relock after manual resync", int'(locked), 1);
    endtask

    task automatic t_window_clear();
        do_reset(2'd0);
        send_good(64);
        for (int i = 0; i < 5; i++) begin
            send_bad();
            send_good(1);
        end
        manual_resync = 1'b1;
        @(negedge clk);
        manual_resync = 1'b0;
        chk("R8 manual edge with auto resync enabled", int'(locked), 0);
        send_good(64);
        chk("R12 relocked", int'(locked), 1);
        for (int i = 0; i < 5; i++) begin
            send_bad();
            send_good(1);
        end
        chk("R12 window emptied by resync", int'(locked), 1);
    endtask

    task automatic t_invert();
        do_reset(2'd0);
        inv_stream = 1'b1;
        invert_en  = 1'b1;
        send_good(63);
        chk("R9 inverted stream not locked at 63", int'(locked), 0);
        send_good(1);
        chk("R9 inverted stream locked at 64", int'(locked), 1);
        do_reset(2'd0);
        inv_stream = 1'b1;
        send_good(200);
        chk("R9 inverted stream without invert never locks", int'(locked), 0);
    endtask

    task automatic t_poly();
        do_reset(2'd1);
        send_good(64);
        chk("R10 pattern 1 (23,18) locks at 64", int'(locked), 1);
        do_reset(2'd3);
        send_good(64);
        chk("R10 pattern 3 (9,5) locks at 64", int'(locked), 1);
        do_reset(2'd0);
        poly_sel = 2'd1;               // stream (15,14), generator (23,18)
        send_good(200);
        chk("R10 wrong pattern never locks", int'(locked), 0);
    endtask

    task automatic t_qrss();
        int errs;
        do_reset(2'd2);
        send_good(100);
        chk("R11 QRSS stream locked", int'(locked), 1);
        errs = 0;
        for (int i = 0; i < 300; i++) begin
            send_good(1);
            if (bit_err) errs++;
        end
        chk("R11 forced ones give no errors", errs, 0);
        chk("R11 lock held through zero runs", int'(locked), 1);
    endtask

    // QRSS test stream: raw recurrence around a near-zero state, then suppression
    initial begin
        int z;
        for (int k = 100; k < 120; k++) raw_q[k] = 1'b0;
        raw_q[119] = 1'b1;
        for (int k = 99; k >= 0; k--) raw_q[k] = raw_q[k+20] ^ raw_q[k+3];
        for (int k = 120; k < 420; k++) raw_q[k] = raw_q[k-20] ^ raw_q[k-17];
        z = 0;
        for (int k = 0; k < 420; k++) begin
            qseq[k] = (z >= 14) ? 1'b1 : raw_q[k];
            z = qseq[k] ? 0 : z + 1;
        end
    end

    // Watchdog
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lock();
        t_verify_fail();
        t_window();
        t_auto_dis_manual();
        t_window_clear();
        t_invert();
        t_poly();
        t_qrss();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule